// File: doc/BRIEF.md
# Byte-Addressed Two-Wire Register Target with User Flags

This block is a two-wire serial bus target that gives a bus controller read and write access to a small bank of byte registers. The system clock oversamples both bus lines. From the sampled lines the block recognises start and stop conditions, matches the 7-bit target address in the first byte of each transfer, and then either takes a register pointer followed by write data, or returns register contents for as long as the controller keeps acknowledging. The block pulls the data line only low. When it does not drive the line low, it releases it.

The bank holds a control register, a register of four general-purpose user flags, and scratch registers. Bit 0 of the control register is a sleep request that leaves the flags untouched. Bit 7 of the control register is a software power-on reset that returns every register to zero in one step. A stop condition always sends the target back to its idle standby state, where it waits for the next start.

Top module: `ftgt_i2c_target`

## Requirements
- R1: After reset the target releases the data line, the user flags read 0000 and the sleep request is 0.
- R2: No byte is acknowledged before a start condition. A first byte whose upper seven bits differ from the configured target address (default 0x2C) gets no acknowledge, and the bytes that follow it are ignored until the next start.
- R3: Bytes are received MSB first. On a matching first byte with bit 0 = 0 (write), the target pulls the data line low during the ninth clock, and it does the same after each register-pointer byte and each data byte.
- R4: In a write, the second byte sets the register pointer and each further byte is stored at the pointer. Register 1 holds the flags in bits 3:0, bits 7:4 of register 1 always read 0, and the flag output follows bits 3:0.
- R5: The pointer advances by one after every data byte and wraps from the last register to register 0. A pointer byte is taken modulo the bank size (4 by default).
- R6: On a matching first byte with bit 0 = 1 (read), the target drives the register at the current pointer MSB first, starting at the falling clock edge that ends the acknowledge. A repeated start keeps the pointer.
- R7: In a read, an acknowledge from the controller makes the target send the next register, and the pointer wraps at the end of the bank.
- R8: After the controller leaves a read byte unacknowledged, the target releases the data line and drives nothing on later clocks until a new start.
- R9: A stop condition returns the target to idle. Clocks after a stop draw no acknowledge until a start is seen.
- R10: Writing register 0 sets the sleep request from bit 0 and leaves the user flags unchanged.
- R11: Writing register 0 with bit 7 set clears every register, including the flags and the sleep request, and register 0 then reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| uflag_o | output | 4 | Current user flag bits |
| sleep_req_o | output | 1 | Sleep request held in the control register |

## Verification
A wrong protocol state shows on the data-line enable within one bus bit. The enable then either misses or adds a low pulse in an acknowledge slot, or it shifts a read bit by one position. The bench sees this in the next high phase of the bus clock. A wrong pointer or a wrong register value shows only at the next read of the register concerned. For that reason every write burst is followed by a read burst that covers the whole bank, including both wrap points. A wrong flag or sleep value shows on the dedicated outputs within four system clocks of the write, and the bench compares these outputs against its model in every sampled cycle.

// File: rtl/ftgt_pkg.sv
package ftgt_pkg;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned FLAG_W   = 4;
    localparam int unsigned SRST_BIT = 7;
    localparam int unsigned SLEEP_BIT = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } link_st_e;

    typedef enum logic [1:0] {
        K_DEV,
        K_REG,
        K_DATA
    } rx_kind_e;

    typedef struct packed {
        link_st_e           st;
        rx_kind_e           kind;
        logic [3:0]         cnt;
        logic [BYTE_W-1:0]  shreg;
        logic               rw;
        logic               mack;
        logic               oe;
        logic [BYTE_W-1:0]  ptr;
    } link_s;

    localparam link_s LINK_RST = '{
        st:    ST_IDLE,
        kind:  K_DEV,
        cnt:   4'd0,
        shreg: 8'd0,
        rw:    1'b0,
        mack:  1'b0,
        oe:    1'b0,
        ptr:   8'd0
    };

endpackage

// File: rtl/ftgt_sync.sv
module ftgt_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    localparam int unsigned LINES = 2;

    logic [LINES-1:0] raw_w;
    logic [LINES-1:0] now_w;
    logic [LINES-1:0] prev_d, prev_q;

    assign raw_w = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], raw_w[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign now_w[g] = chain_q[STAGES-1];
    end

    always_comb begin
        prev_d = now_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    // index 0 is the clock line, index 1 the data line
    assign sda_s    = now_w[1];
    assign scl_rise = now_w[0] & ~prev_q[0];
    assign scl_fall = ~now_w[0] & prev_q[0];
    assign start_ev = now_w[0] & prev_q[0] & prev_q[1] & ~now_w[1];
    assign stop_ev  = now_w[0] & prev_q[0] & ~prev_q[1] & now_w[1];

endmodule

// File: rtl/ftgt_regbank.sv
module ftgt_regbank
    import ftgt_pkg::*;
#(
    parameter int unsigned NREG = 4,
    localparam int unsigned AW  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic [FLAG_W-1:0] flags_o,
    output logic              sleep_o
);
    logic                          srst;
    logic [NREG-1:0][BYTE_W-1:0]   view_w;

    assign srst = wr_en && (wr_addr == '0) && wr_data[SRST_BIT];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic hit;
        assign hit = wr_en && (wr_addr == AW'(i));

        if (i == 0) begin : g_ctrl
            logic sleep_d, sleep_q;
            always_comb begin
                sleep_d = sleep_q;
                if (srst)     sleep_d = 1'b0;
                else if (hit) sleep_d = wr_data[SLEEP_BIT];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sleep_q <= 1'b0;
                else        sleep_q <= sleep_d;
            end
            assign view_w[i] = {{(BYTE_W-1){1'b0}}, sleep_q};
        end else if (i == 1) begin : g_flag
            logic [FLAG_W-1:0] flag_d, flag_q;
            always_comb begin
                flag_d = flag_q;
                if (srst)     flag_d = '0;
                else if (hit) flag_d = wr_data[FLAG_W-1:0];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) flag_q <= '0;
                else        flag_q <= flag_d;
            end
            assign view_w[i] = {{(BYTE_W-FLAG_W){1'b0}}, flag_q};

            AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                !wr_en |=> $stable(flag_q)); // R10
        end else begin : g_scr
            logic [BYTE_W-1:0] scr_d, scr_q;
            always_comb begin
                scr_d = scr_q;
                if (srst)     scr_d = '0;
                else if (hit) scr_d = wr_data;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) scr_q <= '0;
                else        scr_q <= scr_d;
            end
            assign view_w[i] = scr_q;
        end
    end

    assign rd_data = view_w[rd_addr];
    assign flags_o = view_w[1][FLAG_W-1:0];
    assign sleep_o = view_w[0][SLEEP_BIT];

    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (flags_o == '0) && !sleep_o && (view_w[NREG-1] == '0)); // R11

    AST_FLAG_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == AW'(1)) |-> (rd_data[BYTE_W-1:FLAG_W] == '0)); // R4

endmodule

// File: rtl/ftgt_link.sv
module ftgt_link
    import ftgt_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR = 7'h2C,
    parameter int unsigned NREG     = 4,
    localparam int unsigned AW      = $clog2(NREG),
    localparam logic [BYTE_W-1:0] PMASK = BYTE_W'(NREG - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic [AW-1:0]     rd_addr,
    output logic              sda_oe
);
    link_s d, q;

    always_comb begin
        d       = q;
        wr_en   = 1'b0;
        wr_data = q.shreg;
        if (stop_ev) begin
            d.st  = ST_IDLE;
            d.oe  = 1'b0;
            d.cnt = '0;
        end else if (start_ev) begin
            d.st   = ST_RX;
            d.kind = K_DEV;
            d.cnt  = '0;
            d.oe   = 1'b0;
        end else begin
            case (q.st)
                ST_RX: begin
                    if (scl_rise && (q.cnt < 4'd8)) begin
                        d.shreg = {q.shreg[BYTE_W-2:0], sda_s};
                        d.cnt   = q.cnt + 4'd1;
                    end else if (scl_fall && (q.cnt == 4'd8)) begin
                        d.cnt = '0;
                        case (q.kind)
                            K_DEV: begin
                                if (q.shreg[7:1] == DEV_ADDR) begin
                                    d.rw = q.shreg[0];
                                    d.st = ST_RX_ACK;
                                    d.oe = 1'b1;
                                end else begin
                                    d.st = ST_IDLE;
                                end
                            end
                            K_REG: begin
                                d.ptr = q.shreg & PMASK;
                                d.st  = ST_RX_ACK;
                                d.oe  = 1'b1;
                            end
                            default: begin
                                wr_en = 1'b1;
                                d.ptr = (q.ptr + 8'd1) & PMASK;
                                d.st  = ST_RX_ACK;
                                d.oe  = 1'b1;
                            end
                        endcase
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        if ((q.kind == K_DEV) && q.rw) begin
                            d.st    = ST_TX;
                            d.shreg = rd_data;
                            d.ptr   = (q.ptr + 8'd1) & PMASK;
                            d.cnt   = '0;
                            d.oe    = ~rd_data[BYTE_W-1];
                        end else begin
                            d.st   = ST_RX;
                            d.oe   = 1'b0;
                            d.cnt  = '0;
                            d.kind = (q.kind == K_DEV) ? K_REG : K_DATA;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == 4'd7) begin
                            d.st   = ST_TX_ACK;
                            d.oe   = 1'b0;
                            d.mack = 1'b0;
                        end else begin
                            d.shreg = {q.shreg[BYTE_W-2:0], 1'b0};
                            d.cnt   = q.cnt + 4'd1;
                            d.oe    = ~q.shreg[BYTE_W-2];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) d.mack = ~sda_s;
                    if (scl_fall) begin
                        if (q.mack) begin
                            d.st    = ST_TX;
                            d.shreg = rd_data;
                            d.ptr   = (q.ptr + 8'd1) & PMASK;
                            d.cnt   = '0;
                            d.oe    = ~rd_data[BYTE_W-1];
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= LINK_RST;
        else        q <= d;
    end

    assign wr_addr = q.ptr[AW-1:0];
    assign rd_addr = q.ptr[AW-1:0];
    assign sda_oe  = q.oe;

    AST_RX_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RX) |-> !q.oe); // R3
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !q.oe); // R8
    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (q.st == ST_IDLE)); // R9
    AST_START_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ev && !stop_ev) |=> (q.st == ST_RX) && (q.cnt == 4'd0) && (q.kind == K_DEV)); // R2
    AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (q.oe != $past(q.oe)) |-> $past(scl_fall || start_ev || stop_ev)); // R3
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= 4'd8); // R3

endmodule

// File: rtl/ftgt_i2c_target.sv
module ftgt_i2c_target
    import ftgt_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR    = 7'h2C,
    parameter int unsigned NREG        = 4,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned AW         = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic [FLAG_W-1:0] uflag_o,
    output logic              sleep_req_o
);
    logic              sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic              wr_en;
    logic [AW-1:0]     wr_addr, rd_addr;
    logic [BYTE_W-1:0] wr_data, rd_data;

    ftgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    ftgt_link #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .sda_oe   (sda_oe_o)
    );

    ftgt_regbank #(.NREG(NREG)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .flags_o (uflag_o),
        .sleep_o (sleep_req_o)
    );

endmodule

// File: tb/sim_ftgt_i2c_target.sv
`timescale 1ns/1ps
module sim_ftgt_i2c_target;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe_o, sleep_req_o;
    logic [3:0] uflag_o;
    wire  sda_bus = m_sda & ~sda_oe_o;

    always #10 clk = ~clk;

    ftgt_i2c_target u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_oe_o(sda_oe_o), .uflag_o(uflag_o), .sleep_req_o(sleep_req_o)
    );

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // behavioural model of the bank
    logic [7:0] m_reg [4];
    logic       chk_en = 1'b0;
    logic       exp_oe = 1'b0;
    string      cur_req = "R1";

    task automatic mw(input int a, input logic [7:0] v);
        int k = a % 4;
        if (k == 0) begin
            if (v[7]) begin
                for (int i = 0; i < 4; i++) m_reg[i] = 8'h00;
            end else m_reg[0] = {7'd0, v[0]};
        end else if (k == 1) m_reg[1] = {4'd0, v[3:0]};
        else m_reg[k] = v;
    endtask

    // compare every sampled clock while the bus clock is high
    always @(negedge clk) begin
        if (rst_n && chk_en && !done) begin
            vectors++;
            if (sda_oe_o !== exp_oe || uflag_o !== m_reg[1][3:0] || sleep_req_o !== m_reg[0][0]) begin
                errors++;
                $display("FAIL %s: oe=%0b flags=%h sleep=%0b expected oe=%0b flags=%h sleep=%0b",
                    cur_req, sda_oe_o, uflag_o, sleep_req_o, exp_oe, m_reg[1][3:0], m_reg[0][0]);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bitc(input logic b, input logic e);
        m_sda = b;
        repeat (Q) @(posedge clk);
        m_scl = 1'b1;
        repeat (2) @(posedge clk);
        exp_oe = e;
        chk_en = 1'b1;
        repeat (Q - 2) @(posedge clk);
        chk_en = 1'b0;
        m_scl = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    task automatic start_c();
        m_sda = 1'b1;
        repeat (Q) @(posedge clk);
        m_scl = 1'b1;
        repeat (Q) @(posedge clk);
        m_sda = 1'b0;
        repeat (Q) @(posedge clk);
        m_scl = 1'b0;
        repeat (Q) @(posedge clk);
    endtask

    task automatic stop_c();
        m_sda = 1'b0;
        repeat (Q) @(posedge clk);
        m_scl = 1'b1;
        repeat (Q) @(posedge clk);
        m_sda = 1'b1;
        repeat (Q) @(posedge clk);
    endtask

    // plain byte; the ack slot is checked against ack
    task automatic send(input logic [7:0] v, input logic ack);
        for (int i = 7; i >= 0; i--) bitc(v[i], 1'b0);
        bitc(1'b1, ack);
    endtask

    // data byte: the model is updated before the ack slot
    task automatic send_data(input int a, input logic [7:0] v);
        for (int i = 7; i >= 0; i--) bitc(v[i], 1'b0);
        mw(a, v);
        bitc(1'b1, 1'b1);
    endtask

    task automatic recv(input int a, input logic mack);
        logic [7:0] e = m_reg[a % 4];
        for (int i = 7; i >= 0; i--) bitc(1'b1, ~e[i]);
        bitc(~mack, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) m_reg[i] = 8'h00;
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", {29'd0, sda_oe_o, sleep_req_o, 1'b0}, 32'd0);
        chk("R1", {28'd0, uflag_o}, 32'd0);

        // R2 traffic before any start, then a foreign address
        cur_req = "R2";
        m_scl = 1'b0;
        repeat (Q) @(posedge clk);
        send(8'h58, 1'b0);
        start_c();
        send(8'h5A, 1'b0);
        send(8'h01, 1'b0);
        stop_c();

        // R3 R4 write flags through pointer 1, upper bits dropped
        cur_req = "R3";
        start_c();
        send(8'h58, 1'b1);
        send(8'h01, 1'b1);
        cur_req = "R4";
        send_data(1, 8'hA5);
        stop_c();
        chk("R4", {28'd0, uflag_o}, 32'h5);

        // R5 burst wraps 3 -> 0 -> 1, then pointer taken modulo 4
        cur_req = "R5";
        start_c();
        send(8'h58, 1'b1);
        send(8'h02, 1'b1);
        send_data(2, 8'h11);
        send_data(3, 8'h22);
        send_data(0, 8'h01);
        send_data(1, 8'hF6);
        stop_c();
        start_c();
        send(8'h58, 1'b1);
        send(8'h07, 1'b1);
        send_data(3, 8'h77);
        stop_c();

        // R6 R7 set pointer, repeated start, read the bank with wrap
        cur_req = "R6";
        start_c();
        send(8'h58, 1'b1);
        send(8'h01, 1'b1);
        start_c();
        send(8'h59, 1'b1);
        recv(1, 1'b1);
        cur_req = "R7";
        recv(2, 1'b1);
        recv(3, 1'b1);
        recv(0, 1'b0);
        stop_c();
        chk("R4", {24'd0, m_reg[1]}, 32'h06);

        // R8 nack then extra clocks draw no drive
        cur_req = "R8";
        start_c();
        send(8'h59, 1'b1);
        recv(1, 1'b0);
        for (int i = 0; i < 9; i++) bitc(1'b1, 1'b0);
        stop_c();

        // R9 clocks after stop are ignored, a start recovers
        cur_req = "R9";
        m_scl = 1'b0;
        repeat (Q) @(posedge clk);
        send(8'h58, 1'b0);
        start_c();
        send(8'h58, 1'b1);
        stop_c();

        // R10 sleep request leaves flags alone
        cur_req = "R10";
        chk("R10", {27'd0, sleep_req_o, uflag_o}, {27'd0, 1'b1, 4'h6});
        start_c();
        send(8'h58, 1'b1);
        send(8'h00, 1'b1);
        send_data(0, 8'h00);
        stop_c();
        chk("R10", {27'd0, sleep_req_o, uflag_o}, {27'd0, 1'b0, 4'h6});
        start_c();
        send(8'h58, 1'b1);
        send(8'h00, 1'b1);
        send_data(0, 8'h01);
        stop_c();
        chk("R10", {27'd0, sleep_req_o, uflag_o}, {27'd0, 1'b1, 4'h6});

        // R11 soft reset clears everything, read back whole bank
        cur_req = "R11";
        start_c();
        send(8'h58, 1'b1);
        send(8'h00, 1'b1);
        send_data(0, 8'h80);
        stop_c();
        chk("R11", {27'd0, sleep_req_o, uflag_o}, 32'd0);
        start_c();
        send(8'h58, 1'b1);
        send(8'h00, 1'b1);
        start_c();
        send(8'h59, 1'b1);
        recv(0, 1'b1);
        recv(1, 1'b1);
        recv(2, 1'b1);
        recv(3, 1'b0);
        stop_c();
        chk("R11", {24'd0, m_reg[2]}, 32'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule